// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block moves received frame bytes into memory buffers that the host has lent to the receiver. The host keeps a circular table of four-word descriptors in memory. Each descriptor names a buffer, gives its size and holds a status byte with an ownership flag. The walker takes frames from a byte stream that carries start and end markers. It checks the next descriptor, stores the bytes through a simple memory port, moves on to further descriptors when one frame fills a buffer, and hands each buffer back with its status. The last descriptor of a frame also receives the frame length.

The memory port addresses 16-bit words and returns read data in the cycle after the request. The port never stalls. The configured ring base is a word address; its two low bits are forced to zero. Descriptor `i` occupies words base+4i to base+4i+3:
- word 0 holds bits 15:0 of the buffer word address.
- word 1 holds bits 23:16 of the buffer address in bits 7:0, and the status byte in bits 15:8.
- word 2 holds the buffer size as the two's-complement negative of the byte count.
- word 3 receives the frame byte count.

The walker raises two one-cycle events for the register block: one when a frame is complete and one when a frame is missed.

Top module: `rx_ring_walker`

## Requirements
- R1: Descriptor i is found at word address (cfg_ring_base with bits 1:0 cleared) + 4*i, using the word layout given above. The status word is always at offset 1.
- R2: Status bit 15 of word 1 (bit 7 of the status byte) marks a descriptor as owned by the walker. The walker stores data only into owned buffers. Every status write it makes leaves that bit cleared.
- R3: The status byte of the first buffer of a frame has bit 1 (start) set. The status byte of the last buffer has bit 0 (end) set. A frame that fits in one buffer gets both bits, so word 1 reads 16'h0300.
- R4: The buffer byte capacity is the low 12 bits of the negated word 2 (16'hFFF8 gives 8 bytes). When a buffer fills before the end marker, the frame continues in the next descriptor. The buffer that was left is written with status word 16'h0200 if it was the first buffer, or 16'h0000 otherwise.
- R5: When a frame ends, word 3 of its last descriptor is written with the total byte count of the frame. Bits 15:12 of that write are zero. Word 3 of earlier buffers in the frame is left untouched.
- R6: rx_done is high for exactly one cycle for each frame that completes.
- R7: If the descriptor is not owned when a frame starts, rx_miss pulses for one cycle and the whole frame is consumed and discarded. That descriptor is not written, and the next frame tries the same descriptor again.
- R8: If the next descriptor is not owned while a frame is still going, the buffer that was left gets status 16'h4600 if it was the first buffer (start, buffer error bit 2, error summary bit 6). The rest of the frame is discarded and neither event fires. The next frame tries the descriptor that was not owned.
- R9: The ring holds 2^cfg_ring_log2 descriptors. After the last descriptor the index wraps to 0, and a value of 0 gives a ring of one descriptor.
- R10: Byte k of a buffer is written at buffer word address + k/2. Even k goes to bits 7:0 (mem_be 2'b01) and odd k goes to bits 15:8 (mem_be 2'b10). Each data write enables exactly one byte lane.
- R11: While no frame is in progress, stream bytes without the start marker are accepted and discarded. No memory write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ring_base | input | 24 | Ring base word address, bits 1:0 ignored |
| cfg_ring_log2 | input | 3 | log2 of the descriptor count |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_sop | input | 1 | Byte is the first of a frame |
| in_eop | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte accepted on this edge |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 24 | Word address |
| mem_be | output | 2 | Byte lane enables for writes |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| rx_done | output | 1 | Frame completed pulse |
| rx_miss | output | 1 | Frame missed pulse |

## Verification
The hardest situation to reach is losing ownership in the middle of a frame. It needs a frame longer than one buffer, an owned first descriptor and an unowned second one. The walker only finds out when it fetches the second descriptor, after the first buffer is already full. The bench prepares the descriptor table so that only the first entry is owned, then sends a 12-byte frame into 8-byte buffers. It checks the error status of the buffer that was left and that neither event fires. Finally it hands the stalled descriptor back and confirms that the next frame lands there.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  localparam logic [7:0] STAT_OWN  = 8'h80;
  localparam logic [7:0] STAT_ERR  = 8'h40;
  localparam logic [7:0] STAT_BUFF = 8'h04;
  localparam logic [7:0] STAT_STP  = 8'h02;
  localparam logic [7:0] STAT_ENP  = 8'h01;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CHECK, S_WPREV, S_WERR,
    S_RDA, S_RDL, S_LEN, S_DATA, S_WSTAT, S_WCNT, S_DROP
  } walk_state_t;

  // buffer size word holds the negated byte capacity
  function automatic logic [15:0] neg_len(input logic [15:0] w);
    return ~w + 16'd1;
  endfunction

  // status byte handed back to the host, ownership always cleared
  function automatic logic [7:0] ret_status(input logic first, input logic last,
                                            input logic err);
    logic [7:0] s;
    s = 8'h00;
    if (first) s = s | STAT_STP;
    if (last)  s = s | STAT_ENP;
    if (err)   s = s | STAT_BUFF | STAT_ERR;
    return s & ~STAT_OWN;
  endfunction

endpackage

// File: rtl/rxw_ring_index.sv
module rxw_ring_index #(
  parameter int ADDR_W = 24,
  parameter int LOG_W  = 3,
  parameter int IDX_W  = (1 << LOG_W) - 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG_W-1:0]  len_log2,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  output logic [ADDR_W-1:0] desc_base
);
  logic [IDX_W:0]   one_sh;
  logic [IDX_W-1:0] mask, idx_q, idx_eff;

  assign one_sh  = (IDX_W+1)'(1) << len_log2;
  assign mask    = one_sh[IDX_W-1:0] - IDX_W'(1);
  assign idx_eff = idx_q & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= (idx_eff + IDX_W'(1)) & mask;
  end

  assign desc_base = {base[ADDR_W-1:2], 2'b00} + ADDR_W'({idx_eff, 2'b00});
endmodule

// File: rtl/rxw_byte_lane.sv
module rxw_byte_lane #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 12
)(
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [CNT_W-1:0]  offset,
  input  logic [7:0]        byte_in,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        be,
  output logic [15:0]       wdata
);
  assign addr  = buf_base + ADDR_W'(offset >> 1);
  assign be    = offset[0] ? 2'b10 : 2'b01;
  assign wdata = {byte_in, byte_in};
endmodule

// File: rtl/rx_ring_walker.sv
module rx_ring_walker
  import rxw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LOG_W  = 3,
  parameter int CNT_W  = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_ring_base,
  input  logic [LOG_W-1:0]  cfg_ring_log2,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              rx_done,
  output logic              rx_miss
);
  localparam int CNT_PAD = 16 - CNT_W;

  walk_state_t       state_q, state_d;
  logic              first_q, prev_first_q, adv;
  logic [7:0]        hi_q;
  logic [ADDR_W-1:0] buf_q, prev_q, desc_base;
  logic [CNT_W-1:0]  len_q, boff_q, fcnt_q;
  logic [ADDR_W-1:0] lane_addr;
  logic [1:0]        lane_be;
  logic [15:0]       lane_wdata;
  logic              buf_full;

  // named internal events for the checker
  logic stat_rd, stat_wr, cnt_wr, data_wr;

  rxw_ring_index #(.ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_index (
    .clk(clk), .rst_n(rst_n), .len_log2(cfg_ring_log2), .base(cfg_ring_base),
    .advance(adv), .desc_base(desc_base));

  rxw_byte_lane #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_lane (
    .buf_base(buf_q), .offset(boff_q), .byte_in(in_data),
    .addr(lane_addr), .be(lane_be), .wdata(lane_wdata));

  assign buf_full = (boff_q + CNT_W'(1)) == len_q;

  always_comb begin
    state_d   = state_q;
    in_ready  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_base;
    mem_be    = 2'b00;
    mem_wdata = 16'h0000;
    rx_done   = 1'b0;
    rx_miss   = 1'b0;
    adv       = 1'b0;
    case (state_q)
      S_IDLE: begin
        in_ready = in_valid & ~in_sop;
        if (in_valid && in_sop) state_d = S_FETCH;
      end
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_base + ADDR_W'(1);
        state_d  = S_CHECK;
      end
      S_CHECK: begin
        if (mem_rdata[15]) state_d = first_q ? S_RDA : S_WPREV;
        else begin
          state_d = first_q ? S_DROP : S_WERR;
          rx_miss = first_q;
        end
      end
      S_WPREV, S_WERR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = prev_q + ADDR_W'(1);
        mem_be    = 2'b10;
        mem_wdata = {ret_status(prev_first_q, 1'b0, state_q == S_WERR), 8'h00};
        state_d   = (state_q == S_WERR) ? S_DROP : S_RDA;
      end
      S_RDA: begin
        mem_req = 1'b1;
        state_d = S_RDL;
      end
      S_RDL: begin
        mem_req  = 1'b1;
        mem_addr = desc_base + ADDR_W'(2);
        state_d  = S_LEN;
      end
      S_LEN: state_d = S_DATA;
      S_DATA: begin
        in_ready = 1'b1;
        if (in_valid) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = lane_addr;
          mem_be    = lane_be;
          mem_wdata = lane_wdata;
          if (in_eop) state_d = S_WSTAT;
          else if (buf_full) begin
            adv     = 1'b1;
            state_d = S_FETCH;
          end
        end
      end
      S_WSTAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_base + ADDR_W'(1);
        mem_be    = 2'b10;
        mem_wdata = {ret_status(first_q, 1'b1, 1'b0), 8'h00};
        state_d   = S_WCNT;
      end
      S_WCNT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_base + ADDR_W'(3);
        mem_be    = 2'b11;
        mem_wdata = {{CNT_PAD{1'b0}}, fcnt_q};
        rx_done   = 1'b1;
        adv       = 1'b1;
        state_d   = S_IDLE;
      end
      S_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_eop) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      first_q      <= 1'b0;
      prev_first_q <= 1'b0;
      hi_q         <= '0;
      buf_q        <= '0;
      prev_q       <= '0;
      len_q        <= '0;
      boff_q       <= '0;
      fcnt_q       <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && in_valid && in_sop) begin
        first_q <= 1'b1;
        fcnt_q  <= '0;
      end
      if (state_q == S_CHECK) hi_q <= mem_rdata[7:0];
      if (state_q == S_RDL)   buf_q <= ADDR_W'({hi_q, mem_rdata});
      if (state_q == S_LEN) begin
        len_q  <= CNT_W'(neg_len(mem_rdata));
        boff_q <= '0;
      end
      if (state_q == S_DATA && in_valid) begin
        boff_q <= boff_q + CNT_W'(1);
        fcnt_q <= fcnt_q + CNT_W'(1);
        if (!in_eop && buf_full) begin
          prev_q       <= desc_base;
          prev_first_q <= first_q;
          first_q      <= 1'b0;
        end
      end
    end
  end

  assign stat_rd = (state_q == S_FETCH);
  assign stat_wr = (state_q == S_WPREV) || (state_q == S_WERR) || (state_q == S_WSTAT);
  assign cnt_wr  = (state_q == S_WCNT);
  assign data_wr = (state_q == S_DATA) && in_valid;
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 12
)(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_done,
  input logic              rx_miss,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_be,
  input logic [15:0]       mem_wdata,
  input logic              stat_rd,
  input logic              stat_wr,
  input logic              cnt_wr,
  input logic              data_wr
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R7
  events_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_done, rx_miss}));

  // R1
  status_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (mem_req && !mem_we && mem_addr[1:0] == 2'b01));

  // R2
  own_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> (mem_we && mem_be == 2'b10 && !mem_wdata[15] && mem_addr[1:0] == 2'b01));

  // R5
  count_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> (mem_we && mem_wdata[15:CNT_W] == '0 && mem_addr[1:0] == 2'b11));

  // R10
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |-> (mem_we && $countones(mem_be) == 1));
endmodule

bind rx_ring_walker rxw_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rxw_chk (
  .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_miss(rx_miss),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
  .mem_wdata(mem_wdata), .stat_rd(stat_rd), .stat_wr(stat_wr),
  .cnt_wr(cnt_wr), .data_wr(data_wr));

// File: tb/test_rx_ring_walker.sv
module test_rx_ring_walker;
  localparam int CLK_P = 10;
  localparam int AW    = 24;
  localparam logic [9:0] RING = 10'h100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_ring_base = 24'h000103;
  logic [2:0]    cfg_ring_log2 = 3'd2;
  logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready, mem_req, mem_we, rx_done, rx_miss;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be;
  logic [15:0]   mem_wdata, mem_rdata;

  logic [15:0] mem [0:1023];
  int checks = 0, fails = 0, done_n = 0, miss_n = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rx_ring_walker i_rx_ring_walker (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base), .cfg_ring_log2(cfg_ring_log2),
    .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rx_done(rx_done), .rx_miss(rx_miss));

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_be[0]) mem[mem_addr[9:0]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem[mem_addr[9:0]][15:8] <= mem_wdata[15:8];
      end else mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (rx_done) done_n++;
    if (rx_miss) miss_n++;
  end

  function automatic logic [9:0] dw(input int i, input int w);
    return RING + 10'(4*i + w);
  endfunction
  function automatic logic [9:0] bw(input int i);
    return 10'h200 + 10'(32*i);
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_desc(input int i, input bit own);
    mem[dw(i,0)] = bw(i);
    mem[dw(i,1)] = own ? 16'h8000 : 16'h0000;
    mem[dw(i,2)] = 16'hFFF8;
    mem[dw(i,3)] = 16'hAAAA;
  endtask

  task automatic do_reset(input logic [2:0] log2);
    rst_n = 1'b0;
    in_valid = 1'b0;
    cfg_ring_log2 = log2;
    for (int a = 0; a < 1024; a++) mem[a] = 16'h0000;
    for (int i = 0; i < 8; i++) set_desc(i, 1'b1);
    done_n = 0;
    miss_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b, input logic sop, input logic eop);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_sop = sop; in_eop = eop;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) push(seed + 8'(k), k == 0, k == n-1);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // byte k of a frame that starts in buffer j, 8-byte buffers
  task automatic check_data(input string req, input int j, input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      logic [15:0] w;
      logic [7:0]  got;
      w   = mem[bw(j + k/8) + 10'((k%8)/2)];
      got = ((k%8)%2 == 1) ? w[15:8] : w[7:0];
      check(req, $sformatf("data byte %0d", k), {8'h00, got}, {8'h00, seed + 8'(k)});
    end
  endtask

  task automatic t_reset;
    do_reset(3'd2);
    #1;
    check("R6", "reset in_ready/mem_req/done/miss",
          {12'h0, in_ready, mem_req, rx_done, rx_miss}, 16'h0000);
  endtask

  task automatic t_single;
    push(8'hEE, 1'b0, 1'b0);
    push(8'hEF, 1'b0, 1'b0);
    send_frame(5, 8'h10);
    check("R3", "desc0 status", mem[dw(0,1)], 16'h0300);
    check("R5", "desc0 count", mem[dw(0,3)], 16'h0005);
    check("R10", "buf0 word2 lanes", mem[bw(0)+10'd2], 16'h0014);
    check("R11", "buf0 word3 untouched", mem[bw(0)+10'd3], 16'h0000);
    check_data("R10", 0, 5, 8'h10);
    check("R6", "done count", 16'(done_n), 16'd1);
  endtask

  task automatic t_chain;
    send_frame(11, 8'h30);
    check("R4", "desc1 status", mem[dw(1,1)], 16'h0200);
    check("R5", "desc1 count untouched", mem[dw(1,3)], 16'hAAAA);
    check("R3", "desc2 status", mem[dw(2,1)], 16'h0100);
    check("R5", "desc2 count", mem[dw(2,3)], 16'h000B);
    check_data("R4", 1, 11, 8'h30);
    check("R6", "done count", 16'(done_n), 16'd2);
  endtask

  task automatic t_wrap;
    send_frame(3, 8'h50);
    check("R9", "desc3 status", mem[dw(3,1)], 16'h0300);
    set_desc(0, 1'b1);
    send_frame(2, 8'h60);
    check("R9", "desc0 after wrap status", mem[dw(0,1)], 16'h0300);
    check("R9", "desc0 after wrap count", mem[dw(0,3)], 16'h0002);
    check("R2", "desc4 outside ring untouched", mem[dw(4,1)], 16'h8000);
    check("R6", "done count", 16'(done_n), 16'd4);
  endtask

  task automatic t_miss;
    do_reset(3'd2);
    set_desc(0, 1'b0);
    send_frame(4, 8'h70);
    check("R7", "miss count", 16'(miss_n), 16'd1);
    check("R7", "done count", 16'(done_n), 16'd0);
    check("R7", "desc0 status untouched", mem[dw(0,1)], 16'h0000);
    check("R7", "desc0 count untouched", mem[dw(0,3)], 16'hAAAA);
    check("R2", "buf0 not written", mem[bw(0)], 16'h0000);
    set_desc(0, 1'b1);
    send_frame(4, 8'h78);
    check("R7", "retry lands in desc0", mem[dw(0,1)], 16'h0300);
    check("R7", "desc1 still owned", mem[dw(1,1)], 16'h8000);
  endtask

  task automatic t_midframe;
    do_reset(3'd2);
    set_desc(1, 1'b0);
    send_frame(12, 8'h80);
    check("R8", "desc0 error status", mem[dw(0,1)], 16'h4600);
    check("R8", "desc0 count untouched", mem[dw(0,3)], 16'hAAAA);
    check("R8", "desc1 untouched", mem[dw(1,1)], 16'h0000);
    check("R8", "no events", 16'(done_n + miss_n), 16'd0);
    set_desc(1, 1'b1);
    send_frame(3, 8'h90);
    check("R8", "next frame in desc1", mem[dw(1,1)], 16'h0300);
    check("R8", "desc1 count", mem[dw(1,3)], 16'h0003);
  endtask

  task automatic t_ring_one;
    do_reset(3'd0);
    send_frame(4, 8'hA0);
    check("R9", "ring of one first", mem[dw(0,3)], 16'h0004);
    set_desc(0, 1'b1);
    send_frame(2, 8'hB0);
    check("R9", "ring of one again", mem[dw(0,3)], 16'h0002);
    check("R9", "desc1 unused", mem[dw(1,1)], 16'h8000);
    check("R1", "data at buffer base", mem[bw(0)], 16'hB1B0);
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_single();
    t_chain();
    t_wrap();
    t_miss();
    t_midframe();
    t_ring_one();
    finish_up();
  end
endmodule